// File: doc/BRIEF.md
# I2C Slave Address Detector

This block decides whether the current I2C transfer is addressed to this node. A bus front end, outside this block, reports START and STOP conditions as one-cycle pulses and hands over each received byte with a one-cycle valid strobe. The detector only looks at the first byte after each START or repeated START. It compares the upper seven bits of that byte with a programmed own address. When general-call recognition is enabled, it also accepts the all-zero write address.

On a hit it emits a one-cycle match pulse. It also latches two values: whether the hit was a general call, and the direction bit, which is the byte's LSB. It then presents the ninth-bit response for the bus driver. A separate acknowledge-enable control chooses between ACK (SDA held low) and NACK (SDA released). A hit is still reported when NACK is returned.

The logic is a small four-state session tracker, a combinational comparator and a handful of capture flops, so it can stay clocked while the rest of the device sleeps. It raises a wake request for as long as the node is addressed. The tracker states are:

- IDLE: no START seen since reset or since the last STOP.
- WAIT_ADDR: a START was seen and the next byte is the address.
- ADDRESSED: that byte matched.
- IGNORED: that byte did not match.

The tracker transitions are:

- Any state goes to WAIT_ADDR on a START pulse.
- Any state goes to IDLE on a STOP pulse.
- WAIT_ADDR goes to ADDRESSED on a matching byte strobe.
- WAIT_ADDR goes to IGNORED on a non-matching byte strobe.
- In IDLE, ADDRESSED and IGNORED, byte strobes leave the state unchanged.

Top module: `slv_addr_detect`

## Requirements
- R1: When the first byte after a START has bits [7:1] equal to a non-zero own address, match_pulse is 1 in the cycle after the byte strobe and in that cycle only. An own address of zero never produces an own-address hit.
- R2: When gc_en is 1 and the first byte after a START is 8'h00, match_pulse is 1 and gc_flag is 1 in the cycle after the strobe.
- R3: When gc_en is 0, a byte 8'h00 gives no match. The byte 8'h01 (general call with the read bit) is never matched as a general call.
- R4: dir_rd takes bit 0 of each evaluated address byte (1 = master reads) one cycle after the strobe. It holds that value until the next evaluated address byte.
- R5: sda_drive_low is 1 (ACK, SDA pulled low) after a hit with ack_en 1. It is 0 (NACK, SDA released) after a hit with ack_en 0, where match_pulse is still 1, and after a miss. It returns to 0 on the next byte strobe, START or STOP.
- R6: Bytes after the first byte of a transfer are not compared, even when they equal the own address.
- R7: Bytes received after reset or after a STOP, with no START since, are ignored.
- R8: wake_req rises together with match_pulse. It stays 1 until the next START or STOP, and it returns to 0 one cycle after that pulse.
- R9: After reset, match_pulse, gc_flag, dir_rd, sda_drive_low and wake_req are all 0.
- R10: A byte strobe in the same cycle as a START is discarded, and the byte after it is treated as the address.
- R11: A repeated START while addressed leads to a fresh comparison of the next byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_seen | input | 1 | One-cycle pulse on START or repeated START |
| stop_seen | input | 1 | One-cycle pulse on STOP |
| rx_valid | input | 1 | One-cycle strobe: rx_byte holds a received byte |
| rx_byte | input | 8 | Received byte, address in [7:1], direction in [0] |
| own_addr | input | 7 | Programmed slave address |
| gc_en | input | 1 | Enables general-call recognition |
| ack_en | input | 1 | 1: acknowledge a hit; 0: answer NACK |
| match_pulse | output | 1 | One-cycle pulse on an address hit |
| gc_flag | output | 1 | Last evaluated address was a general call |
| dir_rd | output | 1 | Direction bit of the last evaluated address |
| sda_drive_low | output | 1 | Ninth-bit response: 1 drives SDA low (ACK) |
| wake_req | output | 1 | Wake request, high while addressed |

## Verification
The assertions assume the front end never raises START and STOP in the same cycle, and that every strobe lasts exactly one clock. Under those assumptions, a hit is always followed by a cycle outside WAIT_ADDR. The bench drives each pulse for exactly one cycle, from the falling edge. It never overlaps START with STOP, and it changes own_addr, gc_en and ack_en only while no strobe is active. The only deliberate overlap is a START with a byte strobe, used to check that the byte is discarded.

// File: rtl/slv_addr_pkg.sv
package slv_addr_pkg;
    typedef enum logic [1:0] {
        ST_IDLE      = 2'd0,
        ST_WAIT_ADDR = 2'd1,
        ST_ADDRESSED = 2'd2,
        ST_IGNORED   = 2'd3
    } sess_state_t;
endpackage

// File: rtl/slv_addr_cmp.sv
module slv_addr_cmp #(
    parameter int ADDR_W = 7,
    localparam int BYTE_W = ADDR_W + 1
) (
    input  logic [BYTE_W-1:0] rx_byte,
    input  logic [ADDR_W-1:0] own_addr,
    input  logic              gc_en,
    output logic              own_hit,
    output logic              gc_hit,
    output logic              any_hit
);
    localparam logic [BYTE_W-1:0] GC_BYTE = '0;

    always_comb begin
        // zero is reserved for the general call, never an own address
        own_hit = (rx_byte[BYTE_W-1:1] == own_addr) && (own_addr != '0);
        gc_hit  = gc_en && (rx_byte == GC_BYTE);
        any_hit = own_hit || gc_hit;
    end
endmodule

// File: rtl/slv_sess_fsm.sv
module slv_sess_fsm
    import slv_addr_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start_seen,
    input  logic        stop_seen,
    input  logic        rx_valid,
    input  logic        any_hit,
    output sess_state_t state,
    output logic        eval_now
);
    sess_state_t state_nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        eval_now = (state == ST_WAIT_ADDR) && rx_valid && !start_seen && !stop_seen;
        state_nx = state;
        if (start_seen) begin
            state_nx = ST_WAIT_ADDR;
        end else if (stop_seen) begin
            state_nx = ST_IDLE;
        end else begin
            unique case (state)
                ST_IDLE:      state_nx = ST_IDLE;
                ST_WAIT_ADDR: if (rx_valid) state_nx = any_hit ? ST_ADDRESSED : ST_IGNORED;
                ST_ADDRESSED: state_nx = ST_ADDRESSED;
                ST_IGNORED:   state_nx = ST_IGNORED;
                default:      state_nx = ST_IDLE;
            endcase
        end
    end

    p_idle_ignores_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && !start_seen) |=> state != ST_ADDRESSED);
    p_first_byte_resolves_r6: assert property (@(posedge clk) disable iff (!rst_n)
        eval_now |=> (state == ST_ADDRESSED || state == ST_IGNORED));
    p_start_reopens_r11: assert property (@(posedge clk) disable iff (!rst_n)
        start_seen |=> state == ST_WAIT_ADDR);
endmodule

// File: rtl/slv_resp_reg.sv
module slv_resp_reg (
    input  logic clk,
    input  logic rst_n,
    input  logic eval_now,
    input  logic clr_resp,
    input  logic own_hit,
    input  logic gc_hit,
    input  logic dir_bit,
    input  logic ack_en,
    output logic match_pulse,
    output logic gc_flag,
    output logic dir_rd,
    output logic sda_drive_low
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            match_pulse   <= 1'b0;
            gc_flag       <= 1'b0;
            dir_rd        <= 1'b0;
            sda_drive_low <= 1'b0;
        end else if (eval_now) begin
            match_pulse   <= own_hit || gc_hit;
            gc_flag       <= gc_hit;
            dir_rd        <= dir_bit;
            sda_drive_low <= (own_hit || gc_hit) && ack_en;
        end else begin
            match_pulse <= 1'b0;
            if (clr_resp) sda_drive_low <= 1'b0;
        end
    end

    p_pulse_single_r1: assert property (@(posedge clk) disable iff (!rst_n)
        match_pulse |=> !match_pulse);
    p_ack_needs_match_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_drive_low) |-> match_pulse);
    p_gc_is_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (match_pulse && gc_flag) |-> !dir_rd);
endmodule

// File: rtl/slv_addr_detect.sv
module slv_addr_detect
    import slv_addr_pkg::*;
#(
    parameter int ADDR_W = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_seen,
    input  logic              stop_seen,
    input  logic              rx_valid,
    input  logic [ADDR_W:0]   rx_byte,
    input  logic [ADDR_W-1:0] own_addr,
    input  logic              gc_en,
    input  logic              ack_en,
    output logic              match_pulse,
    output logic              gc_flag,
    output logic              dir_rd,
    output logic              sda_drive_low,
    output logic              wake_req
);
    logic        own_hit, gc_hit, any_hit, eval_now;
    sess_state_t state;

    slv_addr_cmp #(.ADDR_W(ADDR_W)) cmp_i (
        .rx_byte (rx_byte),
        .own_addr(own_addr),
        .gc_en   (gc_en),
        .own_hit (own_hit),
        .gc_hit  (gc_hit),
        .any_hit (any_hit)
    );

    slv_sess_fsm fsm_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_seen(start_seen),
        .stop_seen (stop_seen),
        .rx_valid  (rx_valid),
        .any_hit   (any_hit),
        .state     (state),
        .eval_now  (eval_now)
    );

    slv_resp_reg resp_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .eval_now     (eval_now),
        .clr_resp     (rx_valid || start_seen || stop_seen),
        .own_hit      (own_hit),
        .gc_hit       (gc_hit),
        .dir_bit      (rx_byte[0]),
        .ack_en       (ack_en),
        .match_pulse  (match_pulse),
        .gc_flag      (gc_flag),
        .dir_rd       (dir_rd),
        .sda_drive_low(sda_drive_low)
    );

    assign wake_req = (state == ST_ADDRESSED);

    p_wake_with_match_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wake_req) |-> match_pulse);
    p_stop_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_seen && !start_seen) |=> (!wake_req && !sda_drive_low));
endmodule

// File: tb/slv_addr_detect_tb.sv
module slv_addr_detect_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_seen = 1'b0, stop_seen = 1'b0, rx_valid = 1'b0;
    logic [7:0] rx_byte = 8'h00;
    logic [6:0] own_addr = 7'h00;
    logic       gc_en = 1'b0, ack_en = 1'b1;
    logic       match_pulse, gc_flag, dir_rd, sda_drive_low, wake_req;
    int         n_vec = 0, n_bad = 0;
    bit         done = 1'b0;

    always #4 clk = ~clk;

    slv_addr_detect dut_i (
        .clk(clk), .rst_n(rst_n), .start_seen(start_seen), .stop_seen(stop_seen),
        .rx_valid(rx_valid), .rx_byte(rx_byte), .own_addr(own_addr), .gc_en(gc_en),
        .ack_en(ack_en), .match_pulse(match_pulse), .gc_flag(gc_flag), .dir_rd(dir_rd),
        .sda_drive_low(sda_drive_low), .wake_req(wake_req)
    );

    task automatic chk(input string req, input string what, input logic act, input logic exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
        end
    endtask

    // one-cycle pulses driven from the falling edge; on return the edge that took them has passed
    task automatic do_start();
        start_seen = 1'b1; @(negedge clk); start_seen = 1'b0;
    endtask
    task automatic do_stop();
        stop_seen = 1'b1; @(negedge clk); stop_seen = 1'b0;
    endtask
    task automatic do_byte(input logic [7:0] b);
        rx_byte = b; rx_valid = 1'b1; @(negedge clk); rx_valid = 1'b0;
    endtask

    function automatic logic exp_hit(input logic [7:0] b, input logic [6:0] own, input logic ge);
        return ((b[7:1] == own) && (own != 7'h00)) || (ge && b == 8'h00);
    endfunction

    task automatic t_reset();
        chk("R9", "match_pulse", match_pulse, 1'b0);
        chk("R9", "gc_flag", gc_flag, 1'b0);
        chk("R9", "dir_rd", dir_rd, 1'b0);
        chk("R9", "sda_drive_low", sda_drive_low, 1'b0);
        chk("R9", "wake_req", wake_req, 1'b0);
    endtask

    task automatic t_own_sweep();
        for (int i = 0; i < 6; i++) begin
            logic [6:0] a;
            logic [7:0] b;
            logic       h;
            a = 7'(7'h11 * (i + 1) + 3);
            own_addr = a; gc_en = 1'b0; ack_en = 1'b1;
            b = (i % 2 == 0) ? {a, 1'b1} : {a ^ 7'(i), 1'b0};
            h = exp_hit(b, a, 1'b0);
            do_start(); do_byte(b);
            chk("R1", "match_pulse", match_pulse, h);
            chk("R4", "dir_rd", dir_rd, b[0]);
            chk("R5", "sda_drive_low", sda_drive_low, h);
            chk("R8", "wake_req", wake_req, h);
            @(negedge clk);
            chk("R1", "match_pulse second cycle", match_pulse, 1'b0);
            chk("R5", "sda held", sda_drive_low, h);
            do_stop();
            chk("R8", "wake after stop", wake_req, 1'b0);
            chk("R5", "sda after stop", sda_drive_low, 1'b0);
        end
    endtask

    task automatic t_gcall();
        own_addr = 7'h2A; ack_en = 1'b1;
        gc_en = 1'b1; do_start(); do_byte(8'h00);
        chk("R2", "gc match", match_pulse, 1'b1);
        chk("R2", "gc_flag", gc_flag, 1'b1);
        chk("R4", "gc dir", dir_rd, 1'b0);
        do_stop();
        gc_en = 1'b0; do_start(); do_byte(8'h00);
        chk("R3", "gc disabled", match_pulse, 1'b0);
        chk("R3", "gc disabled sda", sda_drive_low, 1'b0);
        do_stop();
        gc_en = 1'b1; do_start(); do_byte(8'h01);
        chk("R3", "gc read", match_pulse, 1'b0);
        chk("R3", "gc read flag", gc_flag, 1'b0);
        do_stop();
        own_addr = 7'h00; gc_en = 1'b0; do_start(); do_byte(8'h00);
        chk("R1", "own zero", match_pulse, 1'b0);
        do_stop();
    endtask

    task automatic t_noack();
        own_addr = 7'h35; gc_en = 1'b0; ack_en = 1'b0;
        do_start(); do_byte({7'h35, 1'b0});
        chk("R5", "nack match", match_pulse, 1'b1);
        chk("R5", "nack sda", sda_drive_low, 1'b0);
        do_stop(); ack_en = 1'b1;
        do_start(); do_byte({7'h35, 1'b0});
        chk("R5", "ack sda", sda_drive_low, 1'b1);
        do_byte(8'h5A);
        chk("R5", "sda cleared by next byte", sda_drive_low, 1'b0);
        do_stop();
    endtask

    task automatic t_data_ignored();
        own_addr = 7'h44; gc_en = 1'b0; ack_en = 1'b1;
        do_start(); do_byte({7'h44, 1'b1});
        do_byte({7'h44, 1'b0});
        chk("R6", "second byte", match_pulse, 1'b0);
        chk("R4", "dir held", dir_rd, 1'b1);
        chk("R8", "wake held", wake_req, 1'b1);
        do_stop();
        do_start(); do_byte(8'h10); do_byte({7'h44, 1'b0});
        chk("R6", "match after miss", match_pulse, 1'b0);
        chk("R6", "wake after miss", wake_req, 1'b0);
        do_stop();
        do_byte({7'h44, 1'b0});
        chk("R7", "no start", match_pulse, 1'b0);
        chk("R7", "no start wake", wake_req, 1'b0);
    endtask

    task automatic t_restart();
        own_addr = 7'h51; gc_en = 1'b0; ack_en = 1'b1;
        do_start(); do_byte({7'h51, 1'b0});
        do_start();
        chk("R8", "wake after restart", wake_req, 1'b0);
        do_byte({7'h51, 1'b1});
        chk("R11", "restart match", match_pulse, 1'b1);
        chk("R11", "restart dir", dir_rd, 1'b1);
        do_stop();
        rx_byte = {7'h51, 1'b0}; rx_valid = 1'b1; start_seen = 1'b1;
        @(negedge clk); rx_valid = 1'b0; start_seen = 1'b0;
        chk("R10", "byte with start", match_pulse, 1'b0);
        do_byte({7'h51, 1'b0});
        chk("R10", "byte after start", match_pulse, 1'b1);
        do_stop();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_own_sweep();
        t_gcall();
        t_noack();
        t_data_ignored();
        t_restart();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_vec++; n_bad++;
            $display("FAIL watchdog: actual running expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end
endmodule